// File: doc/BRIEF.md
# Event Identifier Synchronism Checker

This block confirms, event by event, that the identifiers announced by the trigger distribution system agree with the identifiers found in the header of the matching front-end data fragment. Each trigger accept brings a level-1 event number, a bunch-crossing number and a trigger type. These arrive a few microseconds after the accept, well before the fragment. The block therefore holds them in an ordered queue. When a fragment header is decoded, the oldest queued record is taken out and compared field by field with it.

For every fragment the block issues a one-cycle result. The result carries a two-bit code that says which identifier disagreed, or a separate underflow flag when no trigger record was waiting. Errors also set sticky status bits and advance a saturating error counter. A control pulse clears both. A busy output, with hysteresis on the queue occupancy, tells the trigger system to hold further accepts. The default sizing gives room for a sustained 100 kHz accept rate.

Top module: `evid_sync_checker`

## Requirements
- R1: Trigger records are paired with fragments strictly in arrival order, and the queue holds up to 16 records by default.
- R2: `res_valid` is high in exactly the cycle after each cycle in which `frag_valid` is high, and low otherwise.
- R3: In a result, `res_code` bit 0 is set when the event ID differs and bit 1 when the crossing ID differs. `res_mismatch` is the OR of the two bits, and `res_type` returns the trigger type of the paired record. All result fields read zero when no result is presented.
- R4: A fragment that arrives while the queue held no record before that clock edge gives `res_underflow`=1 with a zero code, and removes nothing. A trigger record offered in the same cycle is still stored.
- R5: `sticky_err` bit 0 records event-ID mismatches, bit 1 crossing-ID mismatches, bit 2 underflows and bit 3 dropped trigger records. Each bit stays set until `clr_err`. When a new error and a clear fall in the same cycle, the new error is kept.
- R6: `err_count` grows by one for each result with a mismatch or an underflow and stops at its maximum (255 by default). `clr_err` resets it to zero, and an error in the clearing cycle then counts as one.
- R7: `busy` becomes 1 when the queue holds 12 or more records after a clock edge, and becomes 0 when it holds 8 or fewer. Between those levels it keeps its value.
- R8: A trigger record offered while the queue is full and no fragment removes an entry is dropped and sets sticky bit 3. The fragment results that follow are unaffected.
- R9: After reset, `busy`, `res_valid`, all result fields, `sticky_err` and `err_count` are zero, and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trg_valid | input | 1 | Trigger-side record strobe |
| trg_evid | input | 24 | Level-1 event ID from the trigger side |
| trg_bcid | input | 12 | Bunch-crossing ID from the trigger side |
| trg_type | input | 8 | Trigger type |
| frag_valid | input | 1 | Fragment-header strobe |
| frag_evid | input | 24 | Event ID from the fragment header |
| frag_bcid | input | 12 | Crossing ID from the fragment header |
| clr_err | input | 1 | One-cycle clear of sticky status and error counter |
| res_valid | output | 1 | Result strobe |
| res_mismatch | output | 1 | Any identifier disagreed |
| res_code | output | 2 | Bit 0 event ID, bit 1 crossing ID |
| res_underflow | output | 1 | Fragment found the queue empty |
| res_type | output | 8 | Trigger type of the paired record |
| sticky_err | output | 4 | Sticky error status |
| err_count | output | 8 | Saturating error counter |
| busy | output | 1 | Request to stop further accepts |

## Verification
Queue state, sticky status, counter and busy all change on the edge that samples the stimulus. The result fields appear one register later, in the cycle after the fragment strobe. The bench drives each cycle's inputs on the falling edge and steps its queue model by one edge. On the next falling edge it compares every output with that prediction, so each result is checked in the cycle it is due. Same-cycle collisions are placed in directed steps: a trigger together with an underflowing fragment, a push into a full queue together with a pop, and a clear together with a new error.

// File: rtl/evsync_pkg.sv
`timescale 1ns/1ps
package evsync_pkg;
   localparam int unsigned CODE_W   = 2;
   localparam int unsigned CODE_EV  = 0;
   localparam int unsigned CODE_BC  = 1;
   localparam int unsigned STICKY_W = 4;
   localparam int unsigned ST_EV    = 0;
   localparam int unsigned ST_BC    = 1;
   localparam int unsigned ST_UNDER = 2;
   localparam int unsigned ST_DROP  = 3;
endpackage

// File: rtl/evsync_fifo.sv
`timescale 1ns/1ps
module evsync_fifo #(
   parameter int unsigned W     = 44,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [W-1:0]     din,
   output logic [W-1:0]     dout,
   output logic             empty,
   output logic             full,
   output logic             drop,
   output logic [CNT_W-1:0] level,
   output logic [CNT_W-1:0] level_nxt
);
   initial begin
      assert (DEPTH >= 2) else $error("queue depth must be at least 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             pop_ok, push_ok;

   assign empty   = (level == '0);
   assign full    = (level == CNT_W'(DEPTH));
   assign pop_ok  = pop && !empty;
   assign push_ok = push && (!full || pop_ok);
   assign drop    = push && !push_ok;
   assign dout    = mem[rd_ptr];

   generate
      if (DEPTH == (1 << PTR_W)) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_comb begin
      unique case ({push_ok, pop_ok})
         2'b10:   level_nxt = level + 1'b1;
         2'b01:   level_nxt = level - 1'b1;
         default: level_nxt = level;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         level <= level_nxt;
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= din;
   end

   // R1: a removal without a store lowers the occupancy by one
   a_r1_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !empty && !push) |=> (level == $past(level) - 1'b1));
   // R8: an offer into a full queue without a removal leaves it full
   a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (level == CNT_W'(DEPTH)));
   a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      full |=> (level <= CNT_W'(DEPTH)));
endmodule

// File: rtl/evsync_busy.sv
`timescale 1ns/1ps
module evsync_busy #(
   parameter int unsigned CNT_W = 5,
   parameter int unsigned ON    = 12,
   parameter int unsigned OFF   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] level,
   input  logic [CNT_W-1:0] level_nxt,
   output logic             busy
);
   initial begin
      assert (OFF < ON) else $error("busy release level must be below assert level");
      assert (ON < (1 << CNT_W)) else $error("busy level exceeds counter range");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                         busy <= 1'b0;
      else if (level_nxt >= CNT_W'(ON))   busy <= 1'b1;
      else if (level_nxt <= CNT_W'(OFF))  busy <= 1'b0;
   end

   // R7: occupancy and busy always agree at the two thresholds
   a_r7_busy_on: assert property (@(posedge clk) disable iff (!rst_n)
      (level >= CNT_W'(ON)) |-> busy);
   a_r7_busy_off: assert property (@(posedge clk) disable iff (!rst_n)
      (level <= CNT_W'(OFF)) |-> !busy);
   a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (level_nxt > CNT_W'(OFF) && level_nxt < CNT_W'(ON)) |=> $stable(busy));
endmodule

// File: rtl/evsync_cmp.sv
`timescale 1ns/1ps
module evsync_cmp
   import evsync_pkg::*;
#(
   parameter int unsigned EVID_W = 24,
   parameter int unsigned BCID_W = 12,
   parameter int unsigned TYPE_W = 8,
   parameter int unsigned ERR_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frag_valid,
   input  logic [EVID_W-1:0]   frag_evid,
   input  logic [BCID_W-1:0]   frag_bcid,
   input  logic                q_empty,
   input  logic [EVID_W-1:0]   q_evid,
   input  logic [BCID_W-1:0]   q_bcid,
   input  logic [TYPE_W-1:0]   q_type,
   input  logic                q_drop,
   input  logic                clr,
   output logic                res_valid,
   output logic                res_mismatch,
   output logic [CODE_W-1:0]   res_code,
   output logic                res_underflow,
   output logic [TYPE_W-1:0]   res_type,
   output logic [STICKY_W-1:0] sticky,
   output logic [ERR_W-1:0]    err_cnt
);
   localparam logic [ERR_W-1:0] ERR_MAX = '1;

   logic                under, is_err;
   logic [CODE_W-1:0]   code;
   logic [STICKY_W-1:0] set_bits, sticky_base;
   logic [ERR_W-1:0]    cnt_base;

   always_comb begin
      under = frag_valid && q_empty;
      code  = '0;
      if (frag_valid && !q_empty) begin
         code[CODE_EV] = (frag_evid != q_evid);
         code[CODE_BC] = (frag_bcid != q_bcid);
      end
      is_err              = under || (|code);
      set_bits            = '0;
      set_bits[ST_EV]     = code[CODE_EV];
      set_bits[ST_BC]     = code[CODE_BC];
      set_bits[ST_UNDER]  = under;
      set_bits[ST_DROP]   = q_drop;
      sticky_base         = clr ? '0 : sticky;
      cnt_base            = clr ? '0 : err_cnt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid     <= 1'b0;
         res_mismatch  <= 1'b0;
         res_code      <= '0;
         res_underflow <= 1'b0;
         res_type      <= '0;
         sticky        <= '0;
         err_cnt       <= '0;
      end else begin
         res_valid     <= frag_valid;
         res_mismatch  <= |code;
         res_code      <= code;
         res_underflow <= under;
         res_type      <= (frag_valid && !q_empty) ? q_type : '0;
         sticky        <= sticky_base | set_bits;
         err_cnt       <= (is_err && cnt_base != ERR_MAX) ? cnt_base + 1'b1 : cnt_base;
      end
   end

   // R5: without a clear no sticky bit ever falls
   a_r5_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((sticky & $past(sticky)) == $past(sticky)));
   // R6: without a clear the counter moves by at most one and never wraps
   a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + 1'b1));
   a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cnt == ERR_MAX && !clr) |=> (err_cnt == ERR_MAX));
   // R4: an underflow result carries no identifier code
   a_r4_under_code: assert property (@(posedge clk) disable iff (!rst_n)
      res_underflow |-> (res_code == '0 && res_valid));
endmodule

// File: rtl/evid_sync_checker.sv
`timescale 1ns/1ps
module evid_sync_checker
   import evsync_pkg::*;
#(
   parameter int unsigned EVID_W   = 24,
   parameter int unsigned BCID_W   = 12,
   parameter int unsigned TYPE_W   = 8,
   parameter int unsigned DEPTH    = 16,
   parameter int unsigned BUSY_ON  = 12,
   parameter int unsigned BUSY_OFF = 8,
   parameter int unsigned ERR_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trg_valid,
   input  logic [EVID_W-1:0] trg_evid,
   input  logic [BCID_W-1:0] trg_bcid,
   input  logic [TYPE_W-1:0] trg_type,
   input  logic              frag_valid,
   input  logic [EVID_W-1:0] frag_evid,
   input  logic [BCID_W-1:0] frag_bcid,
   input  logic              clr_err,
   output logic              res_valid,
   output logic              res_mismatch,
   output logic [1:0]        res_code,
   output logic              res_underflow,
   output logic [TYPE_W-1:0] res_type,
   output logic [3:0]        sticky_err,
   output logic [ERR_W-1:0]  err_count,
   output logic              busy
);
   localparam int unsigned REC_W = EVID_W + BCID_W + TYPE_W;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   initial begin
      assert (BUSY_ON <= DEPTH) else $error("busy level above queue depth");
      assert (CODE_W == 2 && STICKY_W == 4) else $error("status widths disagree with ports");
   end

   logic [REC_W-1:0] rec_in, rec_head;
   logic             q_empty, q_full, q_drop;
   logic [CNT_W-1:0] q_level, q_level_nxt;

   assign rec_in = {trg_evid, trg_bcid, trg_type};

   evsync_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (trg_valid),
      .pop       (frag_valid),
      .din       (rec_in),
      .dout      (rec_head),
      .empty     (q_empty),
      .full      (q_full),
      .drop      (q_drop),
      .level     (q_level),
      .level_nxt (q_level_nxt)
   );

   evsync_busy #(.CNT_W(CNT_W), .ON(BUSY_ON), .OFF(BUSY_OFF)) u_busy (
      .clk       (clk),
      .rst_n     (rst_n),
      .level     (q_level),
      .level_nxt (q_level_nxt),
      .busy      (busy)
   );

   evsync_cmp #(.EVID_W(EVID_W), .BCID_W(BCID_W), .TYPE_W(TYPE_W), .ERR_W(ERR_W)) u_cmp (
      .clk           (clk),
      .rst_n         (rst_n),
      .frag_valid    (frag_valid),
      .frag_evid     (frag_evid),
      .frag_bcid     (frag_bcid),
      .q_empty       (q_empty),
      .q_evid        (rec_head[REC_W-1 -: EVID_W]),
      .q_bcid        (rec_head[TYPE_W +: BCID_W]),
      .q_type        (rec_head[TYPE_W-1:0]),
      .q_drop        (q_drop),
      .clr           (clr_err),
      .res_valid     (res_valid),
      .res_mismatch  (res_mismatch),
      .res_code      (res_code),
      .res_underflow (res_underflow),
      .res_type      (res_type),
      .sticky        (sticky_err),
      .err_cnt       (err_count)
   );

   // R2: one result per fragment, one cycle later
   a_r2_result_due: assert property (@(posedge clk) disable iff (!rst_n)
      frag_valid |=> res_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !frag_valid |=> !res_valid);
   // R4: fragment against an empty queue reports underflow
   a_r4_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (frag_valid && q_empty) |=> res_underflow);
   // R8: a dropped record is remembered
   a_r8_drop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (trg_valid && q_full && !frag_valid) |=> sticky_err[ST_DROP]);
   a_r7_full_busy: assert property (@(posedge clk) disable iff (!rst_n)
      q_full |-> busy);
endmodule

// File: tb/evid_sync_checker_tb_top.sv
`timescale 1ns/1ps
module evid_sync_checker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trg_valid = 1'b0;
   logic [23:0] trg_evid = '0;
   logic [11:0] trg_bcid = '0;
   logic [7:0]  trg_type = '0;
   logic        frag_valid = 1'b0;
   logic [23:0] frag_evid = '0;
   logic [11:0] frag_bcid = '0;
   logic        clr_err = 1'b0;
   logic        res_valid, res_mismatch, res_underflow, busy;
   logic [1:0]  res_code;
   logic [7:0]  res_type;
   logic [3:0]  sticky_err;
   logic [7:0]  err_count;

   always #5 clk = ~clk;

   evid_sync_checker dut_i (
      .clk(clk), .rst_n(rst_n),
      .trg_valid(trg_valid), .trg_evid(trg_evid), .trg_bcid(trg_bcid), .trg_type(trg_type),
      .frag_valid(frag_valid), .frag_evid(frag_evid), .frag_bcid(frag_bcid),
      .clr_err(clr_err),
      .res_valid(res_valid), .res_mismatch(res_mismatch), .res_code(res_code),
      .res_underflow(res_underflow), .res_type(res_type),
      .sticky_err(sticky_err), .err_count(err_count), .busy(busy)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [23:0] m_ev[$];
   logic [11:0] m_bc[$];
   logic [7:0]  m_ty[$];
   logic [3:0]  e_sticky = '0;
   logic [7:0]  e_cnt = '0;
   bit          e_busy = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic bit busy_next(input int lvl, input bit cur);
      if (lvl >= 12) return 1'b1;
      if (lvl <= 8)  return 1'b0;
      return cur;
   endfunction

   task automatic step(input bit tv, input logic [23:0] te, input logic [11:0] tb,
                       input logic [7:0] tt, input bit fv, input logic [23:0] fe,
                       input logic [11:0] fb, input bit cl);
      int   sz;
      bit   popped, e_uf, ov;
      logic [1:0] e_code;
      logic [7:0] e_type;
      trg_valid = tv; trg_evid = te; trg_bcid = tb; trg_type = tt;
      frag_valid = fv; frag_evid = fe; frag_bcid = fb; clr_err = cl;
      sz = m_ev.size(); popped = 1'b0; e_uf = 1'b0; e_code = '0; e_type = '0; ov = 1'b0;
      if (fv) begin
         if (sz == 0) e_uf = 1'b1;
         else begin
            e_code[0] = (fe != m_ev[0]);
            e_code[1] = (fb != m_bc[0]);
            e_type = m_ty[0];
            void'(m_ev.pop_front()); void'(m_bc.pop_front()); void'(m_ty.pop_front());
            popped = 1'b1;
         end
      end
      if (tv) begin
         if (sz == 16 && !popped) ov = 1'b1;
         else begin m_ev.push_back(te); m_bc.push_back(tb); m_ty.push_back(tt); end
      end
      if (cl) begin e_sticky = '0; e_cnt = '0; end
      e_sticky = e_sticky | {ov, e_uf, e_code};
      if ((e_uf || (|e_code)) && e_cnt != 8'hFF) e_cnt = e_cnt + 8'd1;
      e_busy = busy_next(m_ev.size(), e_busy);
      @(posedge clk);
      @(negedge clk);
      chk(res_valid == fv, "R2", "res_valid", res_valid, fv);
      chk(res_code == e_code && res_mismatch == (|e_code), "R3", "res_code", res_code, e_code);
      chk(res_type == e_type, "R3", "res_type", res_type, e_type);
      chk(res_underflow == e_uf, "R4", "res_underflow", res_underflow, e_uf);
      chk(sticky_err == e_sticky, "R5", "sticky_err", sticky_err, e_sticky);
      chk(err_count == e_cnt, "R6", "err_count", err_count, e_cnt);
      chk(busy == e_busy, "R7", "busy", busy, e_busy);
      trg_valid = 1'b0; frag_valid = 1'b0; clr_err = 1'b0;
   endtask

   task automatic push_only(input logic [23:0] e, input logic [11:0] b, input logic [7:0] t);
      step(1'b1, e, b, t, 1'b0, '0, '0, 1'b0);
   endtask

   task automatic frag_good;
      step(1'b0, '0, '0, '0, 1'b1, m_ev[0], m_bc[0], 1'b0);
   endtask

   task automatic drain;
      while (m_ev.size() > 0) frag_good();
   endtask

   task automatic idle(input bit cl);
      step(1'b0, '0, '0, '0, 1'b0, '0, '0, cl);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(busy == 1'b0 && res_valid == 1'b0 && res_code == '0 && res_underflow == 1'b0,
          "R9", "outputs at reset", {busy, res_valid, res_code, res_underflow}, 0);
      chk(sticky_err == '0 && err_count == '0, "R9", "status at reset",
          {sticky_err, err_count}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1/R3: ordered pairing, matching and each mismatch kind
      push_only(24'h000101, 12'h011, 8'h81);
      push_only(24'h000102, 12'h012, 8'h82);
      push_only(24'h000103, 12'h013, 8'h83);
      push_only(24'h000104, 12'h014, 8'h84);
      frag_good();
      step(1'b0, '0, '0, '0, 1'b1, 24'h000999, 12'h012, 1'b0);
      step(1'b0, '0, '0, '0, 1'b1, 24'h000103, 12'h7FF, 1'b0);
      step(1'b0, '0, '0, '0, 1'b1, 24'hFFFFFF, 12'h000, 1'b0);
      // R5: clear alone, then clear with a simultaneous error
      idle(1'b1);
      // R4: underflow with a trigger in the same cycle
      step(1'b1, 24'h00A000, 12'h0A0, 8'h0A, 1'b1, 24'h00A000, 12'h0A0, 1'b0);
      frag_good();
      step(1'b0, '0, '0, '0, 1'b1, 24'h1, 12'h1, 1'b1);

      // R7/R8: fill past the thresholds, overflow, push and pop when full
      idle(1'b1);
      for (int i = 0; i < 17; i++) push_only(24'(i + 32'h200), 12'(i), 8'(i));
      step(1'b1, 24'h0BEEF0, 12'h0BE, 8'hBE, 1'b1, m_ev[0], m_bc[0], 1'b0);
      for (int i = 0; i < 10; i++) frag_good();
      push_only(24'h0CAFE0, 12'h0CA, 8'hCA);
      drain();
      idle(1'b1);

      // Random traffic with occupancy sweeps (R1..R8)
      for (int seg = 0; seg < 16; seg++) begin
         for (int k = 0; k < 200; k++) begin
            bit tv, fv, cl;
            logic [23:0] fe;
            logic [11:0] fb;
            tv = (seg[0] == 1'b0) ? ($urandom_range(0, 9) < 7) : ($urandom_range(0, 9) < 3);
            fv = (seg[0] == 1'b0) ? ($urandom_range(0, 9) < 3) : ($urandom_range(0, 9) < 7);
            cl = ($urandom_range(0, 63) == 0);
            fe = $urandom; fb = $urandom;
            if (m_ev.size() > 0) begin
               fe = m_ev[0]; fb = m_bc[0];
               if ($urandom_range(0, 5) == 0) fe = fe ^ (24'd1 << $urandom_range(0, 23));
               if ($urandom_range(0, 5) == 0) fb = fb ^ (12'd1 << $urandom_range(0, 11));
            end
            step(tv, 24'($urandom), 12'($urandom), 8'($urandom), fv, fe, fb, cl);
         end
      end
      drain();

      // R6: saturation by repeated underflow
      idle(1'b1);
      for (int i = 0; i < 300; i++) step(1'b0, '0, '0, '0, 1'b1, '0, '0, 1'b0);
      chk(err_count == 8'hFF, "R6", "saturated count", err_count, 8'hFF);
      idle(1'b1);
      chk(err_count == 8'h00, "R6", "count after clear", err_count, 0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule